// File: doc/BRIEF.md
# Dual-Port Synchronous Burst RAM

A true dual-port static memory whose two ports, left and right, run on independent clocks and can reach every word at the same time, including the same word. Every word is 16 bits wide and is split into an upper byte lane (bits 15:8) and a lower byte lane (bits 7:0). Each port has its own address counter, so a host can load a start address once and then stream consecutive words in a burst without presenting new addresses.

Each port samples its address, write data and controls on its own rising clock edge. A port is selected only when both of its chip selects are active, which lets several instances share one address bus for depth expansion. Read data leaves a port either one clock after the access (flow-through) or two clocks after it (pipelined), chosen per port. Pad tristate behaviour is replaced by separate data-in and data-out buses, with a valid flag beside the data-out bus.

Top module: `dpbr_ram`

## Requirements
- R1: The array holds 2**ADDR_W words of 16 bits. ADDR_W may be 2 to 15, so 14 gives 16K words and 15 gives 32K words, and every word can be written and read back.
- R2: A port is selected only while its `*_sel_lo_n` is 0 and its `*_sel_hi` is 1. A deselected port writes nothing, its address counter holds, and its data-out is zero with valid low after the next edge.
- R3: With `*_rd_wr_n` = 0 on a selected port, the word at the access address is written on that edge. `*_lane_hi_n` = 0 enables bits 15:8, `*_lane_lo_n` = 0 enables bits 7:0, and a disabled lane keeps its stored value.
- R4: On a read, a byte lane whose enable is high (inactive) returns zeros on data-out, while valid stays high.
- R5: With `*_pipe` = 0 the data of a read on edge k is on data-out after edge k. With `*_pipe` = 1 it appears after edge k+1 instead.
- R6: On a selected port the counter applies, in priority order, clear to zero (`*_clr_n` = 0), load of `*_addr` (`*_ld_n` = 0), increment (`*_inc_n` = 0), else hold. The access on that edge uses the counter's new value.
- R7: Incrementing from the top address 2**ADDR_W-1 gives address 0.
- R8: While `*_oe_n` is 1, that port's data-out is zero and its valid flag is low, without waiting for a clock edge.
- R9: Both ports may access any words on the same edge. A word written by one port is returned by a later read from the other port.
- R10: When both ports write the same byte lane of the same word on the same edge, the left port's data is stored.
- R11: When the ports share a clock and one port reads a word on the same edge that the other writes it, the read returns the value held before that write.
- R12: After reset the address counters are zero, data-out is zero and valid is low on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| rst_l_n | input | 1 | Left port asynchronous reset, active low |
| l_sel_lo_n | input | 1 | Left chip select, active low |
| l_sel_hi | input | 1 | Left chip select, active high |
| l_rd_wr_n | input | 1 | Left cycle type: 1 read, 0 write |
| l_lane_lo_n | input | 1 | Left lower byte lane enable, active low |
| l_lane_hi_n | input | 1 | Left upper byte lane enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_pipe | input | 1 | Left output mode: 0 flow-through, 1 pipelined |
| l_ld_n | input | 1 | Left counter load from l_addr, active low |
| l_inc_n | input | 1 | Left counter increment, active low |
| l_clr_n | input | 1 | Left counter clear, active low |
| l_addr | input | ADDR_W | Left external address |
| l_din | input | 16 | Left write data |
| l_dout | output | 16 | Left read data |
| l_dout_vld | output | 1 | Left read data valid |
| clk_r | input | 1 | Right port clock |
| rst_r_n | input | 1 | Right port asynchronous reset, active low |
| r_sel_lo_n | input | 1 | Right chip select, active low |
| r_sel_hi | input | 1 | Right chip select, active high |
| r_rd_wr_n | input | 1 | Right cycle type: 1 read, 0 write |
| r_lane_lo_n | input | 1 | Right lower byte lane enable, active low |
| r_lane_hi_n | input | 1 | Right upper byte lane enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_pipe | input | 1 | Right output mode: 0 flow-through, 1 pipelined |
| r_ld_n | input | 1 | Right counter load from r_addr, active low |
| r_inc_n | input | 1 | Right counter increment, active low |
| r_clr_n | input | 1 | Right counter clear, active low |
| r_addr | input | ADDR_W | Right external address |
| r_din | input | 16 | Right write data |
| r_dout | output | 16 | Right read data |
| r_dout_vld | output | 1 | Right read data valid |

## Verification
The two functions that can land on one edge are a write from each port into the same word, and a write on one port against a read of that word on the other. The bench ties both port clocks to one source and drives both ports in the same cycle: first both ports write one word with full lanes and then with split lanes, and the readback must show the left data on every lane the left port wrote. Then the left port writes a word while the right port reads it; the right port must return the old word on that edge and the new one on its next read. All expected words come from a bench-side image of the array built from arithmetic patterns.

// File: rtl/dpbr_pkg.sv
package dpbr_pkg;

   localparam int unsigned NUM_LANES = 2;
   localparam int unsigned NUM_PORTS = 2;

   typedef enum logic [1:0] {
      CTR_HOLD = 2'd0,
      CTR_STEP = 2'd1,
      CTR_LOAD = 2'd2,
      CTR_ZERO = 2'd3
   } ctr_op_e;

   typedef enum logic {
      OUT_FLOW = 1'b0,
      OUT_PIPE = 1'b1
   } out_mode_e;

   // Counter controls are active low; clear outranks load, load outranks step.
   function automatic ctr_op_e ctr_decode(input logic sel, input logic clr_n,
                                          input logic ld_n, input logic inc_n);
      if (!sel)   return CTR_HOLD;
      if (!clr_n) return CTR_ZERO;
      if (!ld_n)  return CTR_LOAD;
      if (!inc_n) return CTR_STEP;
      return CTR_HOLD;
   endfunction

endpackage

// File: rtl/dpbr_addr_ctr.sv
module dpbr_addr_ctr
   import dpbr_pkg::*;
#(
   parameter int unsigned ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              clr_n,
   input  logic              ld_n,
   input  logic              inc_n,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_nxt
);

   localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

   logic [ADDR_W-1:0] addr_q;
   ctr_op_e           op;

   assign op = ctr_decode(sel, clr_n, ld_n, inc_n);

   always_comb begin
      unique case (op)
         CTR_ZERO: addr_nxt = '0;
         CTR_LOAD: addr_nxt = addr_in;
         CTR_STEP: addr_nxt = addr_q + 1'b1;
         default:  addr_nxt = addr_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= addr_nxt;
   end

   assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !clr_n) |=> (addr_q == '0));

   assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && clr_n && !ld_n) |=> (addr_q == $past(addr_in)));

   assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && clr_n && ld_n && !inc_n && addr_q == ADDR_TOP) |=> (addr_q == '0));

   assert_hold_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel) |=> $stable(addr_q));

endmodule

// File: rtl/dpbr_dual_array.sv
module dpbr_dual_array
   import dpbr_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned LANE_W = 8
) (
   input  logic                        clk_a,
   input  logic [ADDR_W-1:0]           a_addr,
   input  logic [NUM_LANES-1:0]        a_lane_we,
   input  logic [NUM_LANES*LANE_W-1:0] a_wdata,
   output logic [NUM_LANES*LANE_W-1:0] a_rdata,
   input  logic                        clk_b,
   input  logic [ADDR_W-1:0]           b_addr,
   input  logic [NUM_LANES-1:0]        b_lane_we,
   input  logic [NUM_LANES*LANE_W-1:0] b_wdata,
   output logic [NUM_LANES*LANE_W-1:0] b_rdata
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   // Each lane keeps one bank per writing port plus one marker bit per bank.
   // Markers that differ mean port A wrote last; equal markers mean port B did.
   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store_a [DEPTH];
      logic [LANE_W-1:0] store_b [DEPTH];
      logic              mark_a  [DEPTH];
      logic              mark_b  [DEPTH];
      logic [LANE_W-1:0] a_q;
      logic [LANE_W-1:0] b_q;
      logic              b_we_eff;

      // Port A wins a same-word, same-lane write on a shared edge.
      assign b_we_eff = b_lane_we[g] && !(a_lane_we[g] && (a_addr == b_addr));

      always_ff @(posedge clk_a) begin
         if (a_lane_we[g]) begin
            store_a[a_addr] <= a_wdata[g*LANE_W +: LANE_W];
            mark_a[a_addr]  <= ~mark_b[a_addr];
         end
         a_q <= (mark_a[a_addr] ^ mark_b[a_addr]) ? store_a[a_addr] : store_b[a_addr];
      end

      always_ff @(posedge clk_b) begin
         if (b_we_eff) begin
            store_b[b_addr] <= b_wdata[g*LANE_W +: LANE_W];
            mark_b[b_addr]  <= mark_a[b_addr];
         end
         b_q <= (mark_a[b_addr] ^ mark_b[b_addr]) ? store_a[b_addr] : store_b[b_addr];
      end

      assign a_rdata[g*LANE_W +: LANE_W] = a_q;
      assign b_rdata[g*LANE_W +: LANE_W] = b_q;
   end

endmodule

// File: rtl/dpbr_read_stage.sv
module dpbr_read_stage
   import dpbr_pkg::*;
#(
   parameter int unsigned LANE_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        pipe_mode,
   input  logic                        oe_n,
   input  logic                        acc_rd,
   input  logic [NUM_LANES-1:0]        acc_lanes,
   input  logic [NUM_LANES*LANE_W-1:0] raw,
   output logic [NUM_LANES*LANE_W-1:0] dout,
   output logic                        dout_vld
);

   localparam int unsigned DW = NUM_LANES * LANE_W;

   logic                 s1_vld;
   logic [NUM_LANES-1:0] s1_lanes;
   logic [DW-1:0]        s1_masked;
   logic                 s2_vld;
   logic [DW-1:0]        s2_data;
   logic [DW-1:0]        pick_data;
   logic                 pick_vld;

   // Stage one is captured on the same edge as the array read register.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld   <= 1'b0;
         s1_lanes <= '0;
      end else begin
         s1_vld   <= acc_rd;
         s1_lanes <= acc_lanes;
      end
   end

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_mask
      assign s1_masked[g*LANE_W +: LANE_W] =
         (s1_vld && s1_lanes[g]) ? raw[g*LANE_W +: LANE_W] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_vld  <= 1'b0;
         s2_data <= '0;
      end else begin
         s2_vld  <= s1_vld;
         s2_data <= s1_masked;
      end
   end

   always_comb begin
      if (out_mode_e'(pipe_mode) == OUT_PIPE) begin
         pick_data = s2_data;
         pick_vld  = s2_vld;
      end else begin
         pick_data = s1_masked;
         pick_vld  = s1_vld;
      end
   end

   assign dout     = oe_n ? '0 : pick_data;
   assign dout_vld = !oe_n && pick_vld;

   assert_oe_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (dout == '0 && !dout_vld));

   assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_vld |-> (dout == '0));

   assert_pipe_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_mode && !oe_n) |-> (dout_vld == $past(s1_vld)));

endmodule

// File: rtl/dpbr_ram.sv
module dpbr_ram
   import dpbr_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned LANE_W = 8
) (
   input  logic                        clk_l,
   input  logic                        rst_l_n,
   input  logic                        l_sel_lo_n,
   input  logic                        l_sel_hi,
   input  logic                        l_rd_wr_n,
   input  logic                        l_lane_lo_n,
   input  logic                        l_lane_hi_n,
   input  logic                        l_oe_n,
   input  logic                        l_pipe,
   input  logic                        l_ld_n,
   input  logic                        l_inc_n,
   input  logic                        l_clr_n,
   input  logic [ADDR_W-1:0]           l_addr,
   input  logic [NUM_LANES*LANE_W-1:0] l_din,
   output logic [NUM_LANES*LANE_W-1:0] l_dout,
   output logic                        l_dout_vld,
   input  logic                        clk_r,
   input  logic                        rst_r_n,
   input  logic                        r_sel_lo_n,
   input  logic                        r_sel_hi,
   input  logic                        r_rd_wr_n,
   input  logic                        r_lane_lo_n,
   input  logic                        r_lane_hi_n,
   input  logic                        r_oe_n,
   input  logic                        r_pipe,
   input  logic                        r_ld_n,
   input  logic                        r_inc_n,
   input  logic                        r_clr_n,
   input  logic [ADDR_W-1:0]           r_addr,
   input  logic [NUM_LANES*LANE_W-1:0] r_din,
   output logic [NUM_LANES*LANE_W-1:0] r_dout,
   output logic                        r_dout_vld
);

   localparam int unsigned DW = NUM_LANES * LANE_W;

   if (ADDR_W < 2 || ADDR_W > 15) begin : g_bad_addr_w
      $error("dpbr_ram: ADDR_W must lie in 2..15");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("dpbr_ram: LANE_W must be at least 1");
   end

   // Port 0 is the left port, port 1 the right port.
   logic [NUM_PORTS-1:0] clk_v, rstn_v, sel_lo_n_v, sel_hi_v, rd_v;
   logic [NUM_PORTS-1:0] lo_n_v, hi_n_v, oen_v, pipe_v, ldn_v, incn_v, clrn_v;
   logic [NUM_PORTS-1:0] sel_v, acc_rd_v, vld_v;
   logic [ADDR_W-1:0]    ain_v     [NUM_PORTS];
   logic [ADDR_W-1:0]    anxt_v    [NUM_PORTS];
   logic [NUM_LANES-1:0] lane_en_v [NUM_PORTS];
   logic [NUM_LANES-1:0] lane_we_v [NUM_PORTS];
   logic [DW-1:0]        din_v     [NUM_PORTS];
   logic [DW-1:0]        raw_v     [NUM_PORTS];
   logic [DW-1:0]        dout_v    [NUM_PORTS];

   assign clk_v      = {clk_r,       clk_l};
   assign rstn_v     = {rst_r_n,     rst_l_n};
   assign sel_lo_n_v = {r_sel_lo_n,  l_sel_lo_n};
   assign sel_hi_v   = {r_sel_hi,    l_sel_hi};
   assign rd_v       = {r_rd_wr_n,   l_rd_wr_n};
   assign lo_n_v     = {r_lane_lo_n, l_lane_lo_n};
   assign hi_n_v     = {r_lane_hi_n, l_lane_hi_n};
   assign oen_v      = {r_oe_n,      l_oe_n};
   assign pipe_v     = {r_pipe,      l_pipe};
   assign ldn_v      = {r_ld_n,      l_ld_n};
   assign incn_v     = {r_inc_n,     l_inc_n};
   assign clrn_v     = {r_clr_n,     l_clr_n};
   assign ain_v[0]   = l_addr;
   assign ain_v[1]   = r_addr;
   assign din_v[0]   = l_din;
   assign din_v[1]   = r_din;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign sel_v[p]     = !sel_lo_n_v[p] && sel_hi_v[p];
      assign acc_rd_v[p]  = sel_v[p] && rd_v[p];
      assign lane_en_v[p] = {!hi_n_v[p], !lo_n_v[p]};
      assign lane_we_v[p] = (sel_v[p] && !rd_v[p]) ? lane_en_v[p] : '0;

      dpbr_addr_ctr #(
         .ADDR_W (ADDR_W)
      ) u_ctr (
         .clk      (clk_v[p]),
         .rst_n    (rstn_v[p]),
         .sel      (sel_v[p]),
         .clr_n    (clrn_v[p]),
         .ld_n     (ldn_v[p]),
         .inc_n    (incn_v[p]),
         .addr_in  (ain_v[p]),
         .addr_nxt (anxt_v[p])
      );

      dpbr_read_stage #(
         .LANE_W (LANE_W)
      ) u_rd (
         .clk       (clk_v[p]),
         .rst_n     (rstn_v[p]),
         .pipe_mode (pipe_v[p]),
         .oe_n      (oen_v[p]),
         .acc_rd    (acc_rd_v[p]),
         .acc_lanes (lane_en_v[p]),
         .raw       (raw_v[p]),
         .dout      (dout_v[p]),
         .dout_vld  (vld_v[p])
      );
   end

   dpbr_dual_array #(
      .ADDR_W (ADDR_W),
      .LANE_W (LANE_W)
   ) u_array (
      .clk_a     (clk_v[0]),
      .a_addr    (anxt_v[0]),
      .a_lane_we (lane_we_v[0]),
      .a_wdata   (din_v[0]),
      .a_rdata   (raw_v[0]),
      .clk_b     (clk_v[1]),
      .b_addr    (anxt_v[1]),
      .b_lane_we (lane_we_v[1]),
      .b_wdata   (din_v[1]),
      .b_rdata   (raw_v[1])
   );

   assign l_dout     = dout_v[0];
   assign l_dout_vld = vld_v[0];
   assign r_dout     = dout_v[1];
   assign r_dout_vld = vld_v[1];

endmodule

// File: tb/dpbr_ram_tb.sv
module dpbr_ram_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 4;
   localparam int DEPTH      = 1 << AW;

   logic clk = 1'b0;
   logic rst_n;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic          l_sel_lo_n, l_sel_hi, l_rd_wr_n, l_lane_lo_n, l_lane_hi_n;
   logic          l_oe_n, l_pipe, l_ld_n, l_inc_n, l_clr_n, l_dout_vld;
   logic [AW-1:0] l_addr;
   logic [15:0]   l_din, l_dout;
   logic          r_sel_lo_n, r_sel_hi, r_rd_wr_n, r_lane_lo_n, r_lane_hi_n;
   logic          r_oe_n, r_pipe, r_ld_n, r_inc_n, r_clr_n, r_dout_vld;
   logic [AW-1:0] r_addr;
   logic [15:0]   r_din, r_dout;

   dpbr_ram #(.ADDR_W(AW), .LANE_W(8)) u_dut (
      .clk_l(clk), .rst_l_n(rst_n),
      .l_sel_lo_n(l_sel_lo_n), .l_sel_hi(l_sel_hi), .l_rd_wr_n(l_rd_wr_n),
      .l_lane_lo_n(l_lane_lo_n), .l_lane_hi_n(l_lane_hi_n), .l_oe_n(l_oe_n),
      .l_pipe(l_pipe), .l_ld_n(l_ld_n), .l_inc_n(l_inc_n), .l_clr_n(l_clr_n),
      .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout), .l_dout_vld(l_dout_vld),
      .clk_r(clk), .rst_r_n(rst_n),
      .r_sel_lo_n(r_sel_lo_n), .r_sel_hi(r_sel_hi), .r_rd_wr_n(r_rd_wr_n),
      .r_lane_lo_n(r_lane_lo_n), .r_lane_hi_n(r_lane_hi_n), .r_oe_n(r_oe_n),
      .r_pipe(r_pipe), .r_ld_n(r_ld_n), .r_inc_n(r_inc_n), .r_clr_n(r_clr_n),
      .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout), .r_dout_vld(r_dout_vld)
   );

   int n_vec = 0;
   int n_bad = 0;
   logic [15:0] model [DEPTH];

   function automatic logic [15:0] pat(input int a, input int salt);
      return 16'((a * 4951 + salt * 241) ^ 42435);
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp,
                        input logic va, input logic ve);
      n_vec++;
      if (act !== exp || va !== ve) begin
         n_bad++;
         $display("FAIL %s: dout=%h vld=%b, expected dout=%h vld=%b", req, act, va, exp, ve);
      end
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic l_idle;
      l_sel_lo_n = 1'b1; l_sel_hi = 1'b0; l_rd_wr_n = 1'b1;
      l_lane_lo_n = 1'b0; l_lane_hi_n = 1'b0; l_oe_n = 1'b0;
      l_ld_n = 1'b1; l_inc_n = 1'b1; l_clr_n = 1'b1; l_addr = '0; l_din = '0;
   endtask

   task automatic r_idle;
      r_sel_lo_n = 1'b1; r_sel_hi = 1'b0; r_rd_wr_n = 1'b1;
      r_lane_lo_n = 1'b0; r_lane_hi_n = 1'b0; r_oe_n = 1'b0;
      r_ld_n = 1'b1; r_inc_n = 1'b1; r_clr_n = 1'b1; r_addr = '0; r_din = '0;
   endtask

   task automatic l_set(input bit rd, input bit ld, input bit inc, input bit clr,
                        input int a, input logic [15:0] d);
      l_sel_lo_n = 1'b0; l_sel_hi = 1'b1; l_rd_wr_n = rd;
      l_ld_n = !ld; l_inc_n = !inc; l_clr_n = !clr; l_addr = AW'(a); l_din = d;
   endtask

   task automatic r_set(input bit rd, input bit ld, input bit inc, input bit clr,
                        input int a, input logic [15:0] d);
      r_sel_lo_n = 1'b0; r_sel_hi = 1'b1; r_rd_wr_n = rd;
      r_ld_n = !ld; r_inc_n = !inc; r_clr_n = !clr; r_addr = AW'(a); r_din = d;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog (R1..R12 run): finished=0, expected finished=1");
      summary();
      $finish;
   end

   initial begin
      int prev;
      l_idle(); r_idle();
      l_pipe = 1'b0; r_pipe = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R12: outputs quiet in reset
      check("R12 left reset", l_dout, 16'h0000, l_dout_vld, 1'b0);
      check("R12 right reset", r_dout, 16'h0000, r_dout_vld, 1'b0);
      rst_n = 1'b1;
      tick();

      // R1 / R6: left burst write of every word, load then increment
      for (int a = 0; a < DEPTH; a++) begin
         l_set(0, a == 0, a != 0, 0, a, pat(a, 0));
         model[a] = pat(a, 0);
         tick();
      end
      l_idle();

      // R12: right counter left reset at zero, hold read hits word 0
      r_set(1, 0, 0, 0, 0, 0);
      tick();
      check("R12 counter zero after reset", r_dout, model[0], r_dout_vld, 1'b1);

      // R9 / R1: right flow-through burst read of left-written words
      for (int a = 0; a < DEPTH; a++) begin
         r_set(1, a == 0, a != 0, 0, a, 0);
         tick();
         check("R9 cross-port burst read", r_dout, model[a], r_dout_vld, 1'b1);
      end
      // R7: increment past the top address wraps to zero
      r_set(1, 0, 1, 0, 0, 0);
      tick();
      check("R7 counter wrap", r_dout, model[0], r_dout_vld, 1'b1);

      // R5: pipelined mode lags one more edge
      r_pipe = 1'b1;
      prev = 0;
      for (int i = 0; i < 8; i++) begin
         int b;
         b = (i * 5 + 3) % DEPTH;
         r_set(1, 1, 0, 0, b, 0);
         tick();
         check("R5 pipelined lag", r_dout, model[prev], r_dout_vld, 1'b1);
         prev = b;
      end
      r_idle();
      tick();
      check("R5 pipelined last word", r_dout, model[prev], r_dout_vld, 1'b1);
      tick();
      check("R5 pipelined drain", r_dout, 16'h0000, r_dout_vld, 1'b0);
      r_pipe = 1'b0;

      // R3: byte-lane writes from the left port
      l_set(0, 1, 0, 0, 5, 16'hBEEF); l_lane_lo_n = 1'b1;
      model[5] = {8'hBE, model[5][7:0]};
      tick();
      l_set(0, 1, 0, 0, 6, 16'h1234); l_lane_lo_n = 1'b0; l_lane_hi_n = 1'b1;
      model[6] = {model[6][15:8], 8'h34};
      tick();
      l_set(0, 1, 0, 0, 7, 16'hFFFF); l_lane_lo_n = 1'b1; l_lane_hi_n = 1'b1;
      tick();
      l_idle();
      for (int a = 5; a <= 7; a++) begin
         r_set(1, 1, 0, 0, a, 0);
         tick();
         check("R3 lane write", r_dout, model[a], r_dout_vld, 1'b1);
      end

      // R4: disabled lanes read as zero
      r_set(1, 1, 0, 0, 5, 0); r_lane_hi_n = 1'b1;
      tick();
      check("R4 upper lane off", r_dout, {8'h00, model[5][7:0]}, r_dout_vld, 1'b1);
      r_lane_hi_n = 1'b0; r_lane_lo_n = 1'b1;
      tick();
      check("R4 lower lane off", r_dout, {model[5][15:8], 8'h00}, r_dout_vld, 1'b1);
      r_lane_lo_n = 1'b0;

      // R8: output enable gates data-out at once
      r_set(1, 1, 0, 0, 9, 0);
      tick();
      check("R8 enabled value", r_dout, model[9], r_dout_vld, 1'b1);
      r_oe_n = 1'b1;
      #1;
      check("R8 output disabled", r_dout, 16'h0000, r_dout_vld, 1'b0);
      r_oe_n = 1'b0;
      #1;
      check("R8 output re-enabled", r_dout, model[9], r_dout_vld, 1'b1);
      r_idle();

      // R2: deselected left port (either select inactive) does nothing
      l_set(0, 1, 0, 0, 8, 16'hDEAD); l_sel_hi = 1'b0;
      tick();
      check("R2 deselect by high select", l_dout, 16'h0000, l_dout_vld, 1'b0);
      l_set(0, 1, 0, 0, 8, 16'hDEAD); l_sel_lo_n = 1'b1;
      tick();
      check("R2 deselect by low select", l_dout, 16'h0000, l_dout_vld, 1'b0);
      l_set(1, 0, 0, 0, 0, 0);
      tick();
      check("R2 counter held at 7", l_dout, model[7], l_dout_vld, 1'b1);
      r_set(1, 1, 0, 0, 8, 0);
      tick();
      check("R2 no write while deselected", r_dout, model[8], r_dout_vld, 1'b1);
      r_idle();

      // R6: counter priority on the left port
      l_set(1, 1, 0, 1, 9, 0);
      tick();
      check("R6 clear beats load", l_dout, model[0], l_dout_vld, 1'b1);
      l_set(1, 1, 1, 0, 11, 0);
      tick();
      check("R6 load beats increment", l_dout, model[11], l_dout_vld, 1'b1);
      l_set(1, 0, 1, 0, 0, 0);
      tick();
      check("R6 increment", l_dout, model[12], l_dout_vld, 1'b1);
      l_set(1, 0, 0, 0, 3, 0);
      tick();
      check("R6 hold", l_dout, model[12], l_dout_vld, 1'b1);

      // R10: simultaneous writes to one word
      l_set(0, 1, 0, 0, 10, 16'h1111);
      r_set(0, 1, 0, 0, 10, 16'h2222);
      model[10] = 16'h1111;
      tick();
      l_set(0, 1, 0, 0, 11, 16'hAAAA); l_lane_hi_n = 1'b1;
      r_set(0, 1, 0, 0, 11, 16'h5555); r_lane_lo_n = 1'b1;
      model[11] = 16'h55AA;
      tick();
      l_idle(); r_idle();
      l_set(1, 1, 0, 0, 10, 0);
      tick();
      check("R10 left wins full word", l_dout, model[10], l_dout_vld, 1'b1);
      l_set(1, 1, 0, 0, 11, 0);
      tick();
      check("R10 split lanes both land", l_dout, model[11], l_dout_vld, 1'b1);

      // R11: read on one port while the other writes the same word
      l_set(0, 1, 0, 0, 12, 16'h7777);
      r_set(1, 1, 0, 0, 12, 0);
      tick();
      check("R11 read returns old word", r_dout, model[12], r_dout_vld, 1'b1);
      model[12] = 16'h7777;
      l_idle();
      r_set(1, 0, 0, 0, 0, 0);
      tick();
      check("R9 new word seen next read", r_dout, model[12], r_dout_vld, 1'b1);

      // R1: final sweep of every word from the left port, pipelined
      l_pipe = 1'b1;
      r_idle();
      for (int a = 0; a < DEPTH; a++) begin
         l_set(1, a == 0, a != 0, 0, a, 0);
         tick();
         if (a > 0) check("R1 full-depth readback", l_dout, model[a-1], l_dout_vld, 1'b1);
      end
      l_idle();
      tick();
      check("R1 full-depth readback last", l_dout, model[DEPTH-1], l_dout_vld, 1'b1);

      summary();
      $finish;
   end

endmodule